// File: doc/BRIEF.md
# DMA Request Router with Edge Events

This block sits between a large group of peripheral DMA request lines and a smaller set of DMA channels. Each request line owns one programmable map entry that names a target channel and carries a valid flag. The router registers every request line, merges the requests that point at the same channel into one level per channel, and turns the changes of that level into single-cycle event pulses. A rising channel level means that a request arrived while the channel saw no request. A falling level marks the end of a receive burst. Any rising event also raises a wake pulse for the transfer engine, so a flow-controlled channel that is stalled waiting for a request can resume.

Software programs the map entries through a simple word-addressed register port. Requests 0 to 63 sit in one contiguous word-aligned window. Requests 64 and up sit in a second window that folds onto index 64 onward. A write that would route a valid entry to a channel the block does not have is refused and reported. The channel transfer logic and the interrupt combining logic connect to the outputs and are not part of this block.

Top module: `reqRouterTop`

## Requirements
- R1: After reset, every map entry reads as zero, and `chReq`, `chRise`, `chFall`, `engineWake` and `mapErr` are all low.
- R2: Map entry i is at byte address 0x100+4*i for i below 64, and at 0x1100+4*(i-64) for i from 64 to NUM_REQ-1. A write stores `regWrData[7:0]`. A read returns the stored byte zero-extended in `regRdData`, with no wait cycle. Any other address reads zero and ignores writes.
- R3: In a map entry, bit 7 is the valid flag and bits 4:0 are the channel number. A request whose entry has bit 7 clear drives no channel.
- R4: `chReq[c]` is the OR of every request whose valid entry names channel c. It follows a change on `dmaReqIn` two clock edges later, and follows a map write one edge after the write.
- R5: `chRise[c]` pulses for exactly one cycle, together with the first cycle in which `chReq[c]` is high after being low.
- R6: `chFall[c]` pulses for exactly one cycle, together with the first cycle in which `chReq[c]` is low after being high.
- R7: `engineWake` is high in exactly those cycles in which at least one `chRise` bit is high.
- R8: A write of a valid entry (bit 7 set) whose channel number is NUM_CH or more leaves the entry unchanged. `mapErr` is then high for the one cycle after that write edge.
- R9: An entry written with bit 7 clear is stored whatever its channel field holds, and `mapErr` stays low.
- R10: When two requests share a channel, a second request rising while the first is still high gives no `chRise`. `chFall` comes only when the last of them drops.
- R11: Moving an active request to another channel by rewriting its entry gives a `chFall` on the old channel and a `chRise` on the new channel, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W | Byte address of the register access |
| regWrEn | input | 1 | Write strobe for the register port |
| regWrData | input | 32 | Write data; only bits 7:0 are kept |
| regRdData | output | 32 | Combinational read data for regAddr |
| mapErr | output | 1 | One-cycle pulse after a refused write |
| dmaReqIn | input | NUM_REQ | Peripheral request lines |
| chReq | output | NUM_CH | Merged request level per channel |
| chRise | output | NUM_CH | Rising-edge event per channel |
| chFall | output | NUM_CH | Falling-edge event per channel |
| engineWake | output | 1 | Wake pulse when any channel rises |

## Verification
A stored map byte that is wrong shows up on `regRdData` as soon as the entry's address is placed on the port. It also shows up on `chReq` two edges after the request that uses the entry next changes. A stale or lost edge register shows up the same way: an extra, missing or doubled `chRise` or `chFall` pulse appears in the first cycle after the merged level changes, and `engineWake` disagrees with the rise vector in that same cycle. A decode fault in either address window shows up as a write that lands on the wrong entry, or as a refused write that still changes the entry. The reference model sees this on the next read of that entry or on the next routed request.

// File: rtl/reqRouterPkg.sv
package reqRouterPkg;
  localparam int ENTRY_W   = 8;
  localparam int CHAN_W    = 5;
  localparam int VALID_BIT = 7;
  localparam int MAP_IDX_W = 7;

  typedef struct packed {
    logic                 wr;
    logic                 bad;
    logic                 hit;
    logic [MAP_IDX_W-1:0] idx;
  } mapStrobe_t;

  function automatic logic entryValid(input logic [ENTRY_W-1:0] e);
    return e[VALID_BIT];
  endfunction

  function automatic logic [CHAN_W-1:0] entryChan(input logic [ENTRY_W-1:0] e);
    return e[CHAN_W-1:0];
  endfunction
endpackage

// File: rtl/reqRouterCtrl.sv
module reqRouterCtrl
  import reqRouterPkg::*;
#(
  parameter int NUM_REQ = 75,
  parameter int NUM_CH  = 16,
  parameter int ADDR_W  = 13,
  parameter int LO_BASE = 'h100,
  parameter int HI_BASE = 'h1100,
  parameter int LO_CNT  = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [ENTRY_W-1:0] wrEntry,
  output mapStrobe_t         strobe,
  output logic               mapErr
);
  localparam int HI_CNT = (NUM_REQ > LO_CNT) ? NUM_REQ - LO_CNT : 0;
  localparam logic [ADDR_W-1:0] LO_BASE_A = ADDR_W'(LO_BASE);
  localparam logic [ADDR_W-1:0] HI_BASE_A = ADDR_W'(HI_BASE);
  localparam logic [ADDR_W-1:0] LO_SPAN   = ADDR_W'(4 * LO_CNT);
  localparam logic [ADDR_W-1:0] HI_SPAN   = ADDR_W'(4 * HI_CNT);

  logic [ADDR_W-1:0] offLo, offHi;
  logic inLo, inHi, chanTooBig, errQ;

  always_comb begin
    offLo      = regAddr - LO_BASE_A;
    offHi      = regAddr - HI_BASE_A;
    inLo       = (regAddr[1:0] == 2'b00) && (regAddr >= LO_BASE_A) && (offLo < LO_SPAN);
    inHi       = (regAddr[1:0] == 2'b00) && (regAddr >= HI_BASE_A) && (offHi < HI_SPAN);
    chanTooBig = {1'b0, entryChan(wrEntry)} >= (CHAN_W + 1)'(NUM_CH);
    strobe.hit = inLo || inHi;
    strobe.idx = inHi ? MAP_IDX_W'(offHi >> 2) + MAP_IDX_W'(LO_CNT)
                      : MAP_IDX_W'(offLo >> 2);
    strobe.bad = regWrEn && strobe.hit && entryValid(wrEntry) && chanTooBig;
    strobe.wr  = regWrEn && strobe.hit && !strobe.bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) errQ <= 1'b0;
    else        errQ <= strobe.bad;
  end

  assign mapErr = errQ;

  // R8: an error pulse only follows a valid write attempt
  assert_err_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mapErr |-> ($past(regWrEn) && $past(wrEntry[VALID_BIT])));

  // R2: no write strobe leaves the decoder without a window hit
  assert_wr_needs_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.wr |-> (strobe.hit && regWrEn));
endmodule

// File: rtl/reqRouterPath.sv
module reqRouterPath
  import reqRouterPkg::*;
#(
  parameter int NUM_REQ = 75,
  parameter int NUM_CH  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  mapStrobe_t         strobe,
  input  logic [ENTRY_W-1:0] wrEntry,
  input  logic [NUM_REQ-1:0] reqIn,
  output logic [ENTRY_W-1:0] rdEntry,
  output logic [NUM_CH-1:0]  chLevel,
  output logic [NUM_CH-1:0]  chRise,
  output logic [NUM_CH-1:0]  chFall,
  output logic               wake
);
  logic [ENTRY_W-1:0] mapMem [NUM_REQ];
  logic [NUM_REQ-1:0] reqQ;
  logic [NUM_CH-1:0]  levComb, levQ, riseQ, fallQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REQ; r++) mapMem[r] <= '0;
    end else if (strobe.wr) begin
      mapMem[strobe.idx] <= wrEntry;
    end
  end

  assign rdEntry = strobe.hit ? mapMem[strobe.idx] : '0;

  always_comb begin
    levComb = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      for (int r = 0; r < NUM_REQ; r++) begin
        if (reqQ[r] && entryValid(mapMem[r]) && (entryChan(mapMem[r]) == CHAN_W'(c)))
          levComb[c] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reqQ  <= '0;
      levQ  <= '0;
      riseQ <= '0;
      fallQ <= '0;
    end else begin
      reqQ  <= reqIn;
      levQ  <= levComb;
      riseQ <= levComb & ~levQ;
      fallQ <= ~levComb & levQ;
    end
  end

  assign chLevel = levQ;
  assign chRise  = riseQ;
  assign chFall  = fallQ;
  assign wake    = |riseQ;

  // R2: an accepted write lands in the addressed entry
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.wr |=> (mapMem[$past(strobe.idx)] == $past(wrEntry)));

  // R8: a refused write leaves the entry as it was
  assert_bad_write_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.bad |=> (mapMem[$past(strobe.idx)] == $past(mapMem[strobe.idx])));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R5: a rise pulse marks a low-to-high step of the channel level
    assert_rise_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      chRise[c] |-> (chLevel[c] && !$past(chLevel[c])));
    // R6: a fall pulse marks a high-to-low step of the channel level
    assert_fall_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      chFall[c] |-> (!chLevel[c] && $past(chLevel[c])));
  end
endmodule

// File: rtl/reqRouterTop.sv
module reqRouterTop
  import reqRouterPkg::*;
#(
  parameter int NUM_REQ = 75,
  parameter int NUM_CH  = 16,
  parameter int ADDR_W  = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  output logic               mapErr,
  input  logic [NUM_REQ-1:0] dmaReqIn,
  output logic [NUM_CH-1:0]  chReq,
  output logic [NUM_CH-1:0]  chRise,
  output logic [NUM_CH-1:0]  chFall,
  output logic               engineWake
);
  mapStrobe_t         strobe;
  logic [ENTRY_W-1:0] rdEntry;
  logic               unusedHiData;

  assign unusedHiData = ^regWrData[31:ENTRY_W];

  reqRouterCtrl #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWrEn(regWrEn),
    .wrEntry(regWrData[ENTRY_W-1:0]), .strobe(strobe), .mapErr(mapErr)
  );

  reqRouterPath #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_path (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wrEntry(regWrData[ENTRY_W-1:0]),
    .reqIn(dmaReqIn), .rdEntry(rdEntry), .chLevel(chReq), .chRise(chRise),
    .chFall(chFall), .wake(engineWake)
  );

  assign regRdData = {{(32-ENTRY_W){1'b0}}, rdEntry};

  // R7: wake is present exactly when some channel reports a rise
  assert_wake_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    engineWake == (chRise != '0));
endmodule

// File: tb/sim_reqRouterTop.sv
module sim_reqRouterTop;
  localparam int NREQ = 75;
  localparam int NCH  = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [12:0]     regAddr = '0;
  logic            regWrEn = 1'b0;
  logic [31:0]     regWrData = '0;
  logic [31:0]     regRdData;
  logic            mapErr;
  logic [NREQ-1:0] dmaReqIn = '0;
  logic [NCH-1:0]  chReq, chRise, chFall;
  logic            engineWake;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  reqRouterTop #(.NUM_REQ(NREQ), .NUM_CH(NCH), .ADDR_W(13)) u0 (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .mapErr(mapErr),
    .dmaReqIn(dmaReqIn), .chReq(chReq), .chRise(chRise), .chFall(chFall),
    .engineWake(engineWake)
  );

  // reference model state
  int mapM [NREQ];
  bit reqM [NREQ];
  bit levM [NCH];
  bit riseM [NCH];
  bit fallM [NCH];
  bit wakeM = 0;
  bit errM = 0;

  function automatic int entryAddr(int i);
    return (i < 64) ? ('h100 + 4 * i) : ('h1100 + 4 * (i - 64));
  endfunction

  function automatic int addrIdx(int a);
    for (int i = 0; i < NREQ; i++) if (entryAddr(i) == a) return i;
    return -1;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREQ; i++) begin mapM[i] = 0; reqM[i] = 0; end
      for (int c = 0; c < NCH; c++) begin levM[c] = 0; riseM[c] = 0; fallM[c] = 0; end
      wakeM = 0; errM = 0;
    end else begin
      wakeM = 0;
      for (int c = 0; c < NCH; c++) begin
        bit nl;
        nl = 0;
        for (int r = 0; r < NREQ; r++)
          if (reqM[r] && mapM[r] >= 128 && (mapM[r] % 32) == c) nl = 1;
        riseM[c] = nl && !levM[c];
        fallM[c] = !nl && levM[c];
        if (riseM[c]) wakeM = 1;
        levM[c] = nl;
      end
      for (int r = 0; r < NREQ; r++) reqM[r] = dmaReqIn[r];
      errM = 0;
      if (regWrEn) begin
        int i, v;
        i = addrIdx(int'(regAddr));
        v = int'(regWrData[7:0]);
        if (i >= 0) begin
          if (v >= 128 && (v % 32) >= NCH) errM = 1;
          else mapM[i] = v;
        end
      end
    end
  end

  // compare against the model on every clock
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      logic [NCH-1:0] eL, eR, eF;
      int ia;
      for (int c = 0; c < NCH; c++) begin eL[c] = levM[c]; eR[c] = riseM[c]; eF[c] = fallM[c]; end
      ia = addrIdx(int'(regAddr));
      check("R4 chReq", 32'(chReq), 32'(eL));
      check("R5 chRise", 32'(chRise), 32'(eR));
      check("R6 chFall", 32'(chFall), 32'(eF));
      check("R7 engineWake", 32'(engineWake), 32'(wakeM));
      check("R8 mapErr", 32'(mapErr), 32'(errM));
      check("R2 regRdData", regRdData, (ia >= 0) ? 32'(mapM[ia]) : 32'h0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected below 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wrMap(input int idx, input int val);
    @(negedge clk);
    regAddr = 13'(entryAddr(idx)); regWrData = 32'hABCD_EF00 | 32'(val); regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic setReq(input int r, input bit v);
    @(negedge clk);
    dmaReqIn[r] = v;
  endtask

  task automatic wait2;
    @(posedge clk); @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 chReq reset", 32'(chReq), 32'h0);
    check("R1 chRise reset", 32'(chRise), 32'h0);
    check("R1 wake/err reset", {30'h0, engineWake, mapErr}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    regAddr = 13'(entryAddr(70)); #1;
    check("R1 entry reset", regRdData, 32'h0);

    wrMap(3, 'h81);
    wrMap(70, 'h8F);
    wrMap(5, 'h02);
    wrMap(10, 'h84);
    wrMap(11, 'h84);
    regAddr = 13'(entryAddr(70)); #1;
    check("R2 upper window read", regRdData, 32'h8F);
    regAddr = 13'h0200; #1;
    check("R2 unmapped read", regRdData, 32'h0);

    wrMap(20, 'h90);
    check("R8 error pulse", 32'(mapErr), 32'h1);
    regAddr = 13'(entryAddr(20)); #1;
    check("R8 entry kept", regRdData, 32'h0);
    wrMap(21, 'h1F);
    check("R9 no error", 32'(mapErr), 32'h0);
    regAddr = 13'(entryAddr(21)); #1;
    check("R9 stored", regRdData, 32'h1F);

    setReq(5, 1); wait2;
    check("R3 invalid entry ignored", 32'(chReq), 32'h0);
    setReq(5, 0);

    setReq(3, 1); wait2;
    check("R5 rise ch1", 32'(chRise), 32'h2);
    check("R7 wake", 32'(engineWake), 32'h1);
    setReq(3, 0); wait2;
    check("R6 fall ch1", 32'(chFall), 32'h2);

    setReq(10, 1); wait2;
    check("R10 first rise ch4", 32'(chRise), 32'h10);
    setReq(11, 1); wait2;
    check("R10 no second rise", 32'(chRise), 32'h0);
    setReq(10, 0); wait2;
    check("R10 level held", {16'h0, chReq}, 32'h10);
    check("R10 no early fall", 32'(chFall), 32'h0);
    setReq(11, 0); wait2;
    check("R10 final fall", 32'(chFall), 32'h10);

    setReq(3, 1); wait2;
    wrMap(3, 'h82);
    @(posedge clk); #1;
    check("R11 old channel fall", 32'(chFall), 32'h2);
    check("R11 new channel rise", 32'(chRise), 32'h4);
    setReq(3, 0);

    begin
      logic [31:0] lfsr;
      int pick [7] = '{3, 5, 10, 11, 21, 70, 74};
      lfsr = 32'h1ACE_B00C;
      wrMap(74, 'h8F);
      for (int n = 0; n < 400; n++) begin
        @(negedge clk);
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        for (int k = 0; k < 7; k++) dmaReqIn[pick[k]] = lfsr[k * 3];
        if (n % 37 == 0) begin
          regAddr = 13'(entryAddr(pick[n % 7])); regWrData = 32'(lfsr[7:0]); regWrEn = 1'b1;
        end else begin
          regWrEn = 1'b0;
          regAddr = 13'(entryAddr(pick[n % 7]));
        end
      end
      @(negedge clk); regWrEn = 1'b0;
    end
    repeat (4) @(posedge clk);
    #2;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule